// File: doc/BRIEF.md
# Activity Counter Bank

This block keeps a bank of cycle counters that measure how busy a set of engines is. Each counter watches its own chosen subset of engine busy lines, combined by OR, and counts according to its own mode: not at all, only on cycles where a selected line is busy, or on every clock. An optional per-counter level filter makes the busy/idle state change only after the new level has held for a programmable number of cycles, so short glitches do not count.

Software reaches the bank through a simple register port: a write strobe with address and data, and a combinational read path. It programs masks, modes, filter settings and the threshold of counter 0, reads counts, clears single counters, and handles one sticky interrupt status bit that is set when counter 0 passes its threshold. The interrupt output is that status gated by an enable bit.

Top module: `activity_ctr_bank`

## Requirements
- R1: After reset every count, mask (address 0x00+i), status (0x19 bit 0) and enable (0x1A bit 0) reads 0, each control register (0x08+i) reads 0x0400 (mode off, filter off, filter length 4), the threshold (0x18) reads 0x7F..F (all ones except the top count bit), and the interrupt output is low.
- R2: A counter whose mode field (control bits [1:0]) is 0 or 3 keeps its value whatever its busy lines do.
- R3: With mode 2 a counter increments by one on every clock edge on which that mode is held in its control register.
- R4: With mode 1 a counter increments on each edge where the OR of its busy lines, selected by the set bits of its mask register, is high; busy lines outside the mask have no effect.
- R5: With the filter enabled (control bit 2) and length L in control bits [15:8] (0 treated as 1), the counted state follows the raw level only after the raw level has differed from it on L consecutive edges; a busy pulse shorter than L cycles adds nothing and a pulse of B ≥ L cycles adds exactly B.
- R6: Writing a value with bit 0 set to a count register (0x10+i) clears that counter to zero on the next edge, taking priority over an increment in the same cycle; a write with bit 0 clear leaves the count unchanged.
- R7: A counter that reaches all ones stays at all ones instead of wrapping.
- R8: The status bit is set on the edge after counter 0 holds a value strictly greater than the threshold; a count equal to the threshold does not set it.
- R9: The status bit remains set until a write to 0x19 with bit 0 set clears it, even if counter 0 is cleared meanwhile.
- R10: The interrupt output is high exactly when the status bit and the enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | NUM_SRC | Engine busy levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| irq_o | output | 1 | Threshold interrupt (status AND enable) |

## Verification
A wrong mode decode or mask gate shows up as a count that differs from the number of busy or elapsed cycles, visible on the next read of the count register once stimulus stops. A broken filter run counter shows as a short glitch being counted or a long pulse counted with a different length, again at the next read. A status bit that is not sticky, or a threshold compare off by one, appears on the status read and on irq_o one edge after counter 0 crosses the threshold or is cleared.

// File: rtl/activity_ctr_pkg.sv
package activity_ctr_pkg;

  typedef enum logic [1:0] {
    ACT_MODE_OFF  = 2'd0,
    ACT_MODE_BUSY = 2'd1,
    ACT_MODE_ALL  = 2'd2,
    ACT_MODE_RSVD = 2'd3
  } act_mode_e;

  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 32;
  localparam int FLEN_W    = 8;
  localparam int FLEN_RST  = 4;

  // address groups: addr[4:3]
  localparam logic [1:0] GRP_MASK = 2'd0;
  localparam logic [1:0] GRP_CTRL = 2'd1;
  localparam logic [1:0] GRP_CNT  = 2'd2;
  localparam logic [1:0] GRP_MISC = 2'd3;

  // indices inside GRP_MISC
  localparam logic [2:0] MISC_THR = 3'd0;
  localparam logic [2:0] MISC_STS = 3'd1;
  localparam logic [2:0] MISC_EN  = 3'd2;

  // control register field positions
  localparam int CTRL_FEN_BIT = 2;
  localparam int CTRL_LEN_LSB = 8;

endpackage

// File: rtl/actc_level_filter.sv
module actc_level_filter #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             state_o
);

  localparam logic [LEN_W:0] ONE = {{LEN_W{1'b0}}, 1'b1};

  logic [LEN_W-1:0] run_q, run_d;
  logic             state_q, state_d;
  logic [LEN_W:0]   run_nxt;
  logic [LEN_W:0]   len_eff;

  always_comb begin
    len_eff = (len_i == '0) ? ONE : {1'b0, len_i};
    run_nxt = {1'b0, run_q} + ONE;
    run_d   = '0;
    state_d = state_q;
    if (raw_i != state_q) begin
      if (run_nxt >= len_eff) begin
        state_d = raw_i;
      end else begin
        run_d = run_nxt[LEN_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      state_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

  AST_FILT_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_i == state_q) |=> $stable(state_q)); // R5

endmodule

// File: rtl/actc_channel.sv
module actc_channel
  import activity_ctr_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] busy_i,
  input  logic              mask_we_i,
  input  logic [NUM_SRC-1:0] mask_wdata_i,
  input  logic              ctrl_we_i,
  input  act_mode_e         mode_wdata_i,
  input  logic              fen_wdata_i,
  input  logic [FLEN_W-1:0] flen_wdata_i,
  input  logic              clr_i,
  output logic [NUM_SRC-1:0] mask_o,
  output act_mode_e         mode_o,
  output logic              fen_o,
  output logic [FLEN_W-1:0] flen_o,
  output logic [CNT_W-1:0]  cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [NUM_SRC-1:0] mask_q;
  act_mode_e          mode_q;
  logic               fen_q;
  logic [FLEN_W-1:0]  flen_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               raw_busy, filt_busy, act_busy, inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we_i) begin
      mask_q <= mask_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ACT_MODE_OFF;
      fen_q  <= 1'b0;
      flen_q <= FLEN_W'(FLEN_RST);
    end else if (ctrl_we_i) begin
      mode_q <= mode_wdata_i;
      fen_q  <= fen_wdata_i;
      flen_q <= flen_wdata_i;
    end
  end

  assign raw_busy = |(busy_i & mask_q);

  actc_level_filter #(.LEN_W(FLEN_W)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_i   (raw_busy),
    .len_i   (flen_q),
    .state_o (filt_busy)
  );

  always_comb begin
    act_busy = fen_q ? filt_busy : raw_busy;
    unique case (mode_q)
      ACT_MODE_ALL:  inc = 1'b1;
      ACT_MODE_BUSY: inc = act_busy;
      default:       inc = 1'b0;
    endcase
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (inc && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign mask_o = mask_q;
  assign mode_o = mode_q;
  assign fen_o  = fen_q;
  assign flen_o = flen_q;
  assign cnt_o  = cnt_q;

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0)); // R6

  AST_CNT_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == CNT_MAX) && !clr_i) |=> (cnt_q == CNT_MAX)); // R7

  AST_CNT_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q != ACT_MODE_ALL) && (mode_q != ACT_MODE_BUSY) && !clr_i) |=> $stable(cnt_q)); // R2

  AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_ONE))); // R3

endmodule

// File: rtl/actc_threshold_irq.sv
module actc_threshold_irq #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt0_i,
  input  logic             thr_we_i,
  input  logic [CNT_W-1:0] thr_wdata_i,
  input  logic             sts_clr_i,
  input  logic             en_we_i,
  input  logic             en_wdata_i,
  output logic [CNT_W-1:0] thr_o,
  output logic             sts_o,
  output logic             en_o,
  output logic             irq_o
);

  localparam logic [CNT_W-1:0] THR_RST = {1'b0, {(CNT_W-1){1'b1}}};

  logic [CNT_W-1:0] thr_q;
  logic             sts_q, sts_d;
  logic             en_q;
  logic             over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= THR_RST;
    end else if (thr_we_i) begin
      thr_q <= thr_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_we_i) begin
      en_q <= en_wdata_i;
    end
  end

  always_comb begin
    over  = (cnt0_i > thr_q);
    sts_d = (sts_q && !sts_clr_i) || over;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
    end
  end

  assign thr_o = thr_q;
  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign irq_o = sts_q & en_q;

  AST_STS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0_i > thr_q) |=> sts_q); // R8

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && !sts_clr_i) |=> sts_q); // R9

endmodule

// File: rtl/activity_ctr_bank.sv
module activity_ctr_bank
  import activity_ctr_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int NUM_SRC = 8,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] busy_i,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq_o
);

  logic [1:0] wr_grp, rd_grp;
  logic [2:0] wr_idx, rd_idx;

  logic [NUM_SRC-1:0] mask_a [NUM_CNT];
  act_mode_e          mode_a [NUM_CNT];
  logic               fen_a  [NUM_CNT];
  logic [FLEN_W-1:0]  flen_a [NUM_CNT];
  logic [CNT_W-1:0]   cnt_a  [NUM_CNT];

  logic [CNT_W-1:0] thr;
  logic             sts, en;
  logic             thr_we, sts_clr, en_we;

  assign wr_grp = wr_addr[4:3];
  assign wr_idx = wr_addr[2:0];
  assign rd_grp = rd_addr[4:3];
  assign rd_idx = rd_addr[2:0];

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_ch
    logic mask_we, ctrl_we, clr;
    assign mask_we = wr_en && (wr_grp == GRP_MASK) && (wr_idx == 3'(i));
    assign ctrl_we = wr_en && (wr_grp == GRP_CTRL) && (wr_idx == 3'(i));
    assign clr     = wr_en && (wr_grp == GRP_CNT)  && (wr_idx == 3'(i)) && wr_data[0];

    actc_channel #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) u_ch (
      .clk          (clk),
      .rst_n        (rst_n),
      .busy_i       (busy_i),
      .mask_we_i    (mask_we),
      .mask_wdata_i (wr_data[NUM_SRC-1:0]),
      .ctrl_we_i    (ctrl_we),
      .mode_wdata_i (act_mode_e'(wr_data[1:0])),
      .fen_wdata_i  (wr_data[CTRL_FEN_BIT]),
      .flen_wdata_i (wr_data[CTRL_LEN_LSB +: FLEN_W]),
      .clr_i        (clr),
      .mask_o       (mask_a[i]),
      .mode_o       (mode_a[i]),
      .fen_o        (fen_a[i]),
      .flen_o       (flen_a[i]),
      .cnt_o        (cnt_a[i])
    );
  end

  assign thr_we  = wr_en && (wr_grp == GRP_MISC) && (wr_idx == MISC_THR);
  assign sts_clr = wr_en && (wr_grp == GRP_MISC) && (wr_idx == MISC_STS) && wr_data[0];
  assign en_we   = wr_en && (wr_grp == GRP_MISC) && (wr_idx == MISC_EN);

  actc_threshold_irq #(.CNT_W(CNT_W)) u_thr (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt0_i      (cnt_a[0]),
    .thr_we_i    (thr_we),
    .thr_wdata_i (wr_data[CNT_W-1:0]),
    .sts_clr_i   (sts_clr),
    .en_we_i     (en_we),
    .en_wdata_i  (wr_data[0]),
    .thr_o       (thr),
    .sts_o       (sts),
    .en_o        (en),
    .irq_o       (irq_o)
  );

  always_comb begin
    rd_data = '0;
    if (rd_grp == GRP_MISC) begin
      unique case (rd_idx)
        MISC_THR: rd_data = 32'(thr);
        MISC_STS: rd_data = 32'(sts);
        MISC_EN:  rd_data = 32'(en);
        default:  rd_data = '0;
      endcase
    end else if (32'(rd_idx) < NUM_CNT) begin
      unique case (rd_grp)
        GRP_MASK: rd_data = 32'(mask_a[rd_idx]);
        GRP_CTRL: rd_data = 32'({flen_a[rd_idx], 5'd0, fen_a[rd_idx], mode_a[rd_idx]});
        GRP_CNT:  rd_data = 32'(cnt_a[rd_idx]);
        default:  rd_data = '0;
      endcase
    end
  end

endmodule

// File: tb/activity_ctr_bank_tb.sv
`timescale 1ns/1ps
module activity_ctr_bank_tb;

  localparam int NSRC = 4;
  localparam int CW   = 8;

  logic            clk;
  logic            rst_n;
  logic [NSRC-1:0] busy_i;
  logic            wr_en;
  logic [4:0]      wr_addr;
  logic [31:0]     wr_data;
  logic [4:0]      rd_addr;
  logic [31:0]     rd_data;
  logic            irq_o;

  activity_ctr_bank #(.NUM_CNT(8), .NUM_SRC(NSRC), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int pushed = 0;
  int popped = 0;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // monitor: samples 2 ns after the driver set up the read, before the next edge
  initial begin
    forever begin
      sb_item_t it;
      logic [31:0] act;
      wait (pushed > popped);
      #2;
      it = sb_q.pop_front();
      popped++;
      act = it.is_irq ? {31'd0, irq_o} : rd_data;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    rd_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    pushed++;
    @(negedge clk);
  endtask

  task automatic expect_irq(input logic e, input string tag);
    sb_item_t it;
    it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
    sb_q.push_back(it);
    pushed++;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [NSRC-1:0] v, input int n);
    busy_i = v;
    idle(n);
    busy_i = '0;
  endtask

  initial begin
    rst_n = 1'b0; busy_i = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // reset state
    expect_rd(5'h08, 32'h0400, "R1 ctrl0 reset");
    expect_rd(5'h18, 32'h7F,   "R1 threshold reset");
    expect_rd(5'h13, 32'h0,    "R1 count3 reset");
    expect_rd(5'h00, 32'h0,    "R1 mask0 reset");
    expect_rd(5'h19, 32'h0,    "R1 status reset");
    expect_rd(5'h1A, 32'h0,    "R1 enable reset");
    expect_irq(1'b0,           "R1 irq reset");

    // always mode on counter 1: 9 idle cycles between the two writes -> 10 counts
    wr(5'h09, 32'h0402);
    idle(9);
    wr(5'h09, 32'h0400);
    expect_rd(5'h11, 32'd10, "R3 always mode count");

    // off mode on counter 2 with all lines busy
    wr(5'h02, 32'hF);
    pulse(4'hF, 6);
    expect_rd(5'h12, 32'd0,  "R2 off mode ignores busy");
    expect_rd(5'h11, 32'd10, "R2 counter1 holds in off mode");

    // busy mode, mask 0x3 on counter 2
    wr(5'h02, 32'h3);
    wr(5'h0A, 32'h0401);
    pulse(4'b0100, 6);
    idle(1);
    expect_rd(5'h12, 32'd0, "R4 unmasked line ignored");
    pulse(4'b0010, 7);
    idle(1);
    expect_rd(5'h12, 32'd7, "R4 single masked line");
    pulse(4'b0011, 3);
    idle(1);
    expect_rd(5'h12, 32'd10, "R4 OR of masked lines");

    // clear and priority
    wr(5'h12, 32'h1);
    expect_rd(5'h12, 32'd0, "R6 clear on write");
    wr(5'h09, 32'h0402);
    idle(5);
    wr(5'h11, 32'h1);
    wr(5'h09, 32'h0400);
    expect_rd(5'h11, 32'd1, "R6 clear wins over increment");
    wr(5'h11, 32'h2);
    expect_rd(5'h11, 32'd1, "R6 write without bit0 ignored");

    // filter on counter 3, length 4
    wr(5'h03, 32'h1);
    wr(5'h0B, 32'h0405);
    pulse(4'b0001, 3);
    idle(8);
    expect_rd(5'h13, 32'd0, "R5 glitch shorter than length");
    pulse(4'b0001, 10);
    idle(8);
    expect_rd(5'h13, 32'd10, "R5 long pulse counted in full");
    // filter length 2
    wr(5'h0B, 32'h0205);
    wr(5'h13, 32'h1);
    pulse(4'b0001, 1);
    idle(6);
    expect_rd(5'h13, 32'd0, "R5 one-cycle glitch with length 2");
    pulse(4'b0001, 5);
    idle(6);
    expect_rd(5'h13, 32'd5, "R5 pulse with length 2");
    wr(5'h0B, 32'h0400);

    // saturation
    wr(5'h0C, 32'h0402);
    idle(300);
    wr(5'h0C, 32'h0400);
    expect_rd(5'h14, 32'hFF, "R7 saturates at all ones");

    // threshold on counter 0
    wr(5'h18, 32'd5);
    wr(5'h00, 32'h1);
    wr(5'h08, 32'h0401);
    pulse(4'b0001, 5);
    idle(3);
    expect_rd(5'h10, 32'd5, "R8 count at threshold");
    expect_rd(5'h19, 32'd0, "R8 equal does not set status");
    pulse(4'b0001, 1);
    idle(3);
    expect_rd(5'h19, 32'd1, "R8 above threshold sets status");
    expect_irq(1'b0, "R10 irq gated off by enable");

    wr(5'h1A, 32'h1);
    expect_irq(1'b1, "R10 irq with status and enable");
    wr(5'h1A, 32'h0);
    expect_irq(1'b0, "R10 irq after enable cleared");
    wr(5'h1A, 32'h1);

    // sticky and clear
    wr(5'h10, 32'h1);
    idle(2);
    expect_rd(5'h10, 32'd0, "R9 counter0 cleared");
    expect_rd(5'h19, 32'd1, "R9 status survives count clear");
    wr(5'h19, 32'h0);
    expect_rd(5'h19, 32'd1, "R9 write of zero keeps status");
    wr(5'h19, 32'h1);
    expect_rd(5'h19, 32'd0, "R9 write one clears status");
    expect_irq(1'b0, "R10 irq low after status clear");

    idle(2);
    wait (popped == pushed);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule